// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block turns event strobes from a protocol engine into an active-low interrupt request line for a host processor. Events set sticky bits in two status registers, A and B. Each status register has its own enable mask, and only an enabled bit can cause a request. A processor reaches the status registers, the masks, a configuration register and a control register through a simple strobe-based register port. The read port is combinational.

The configuration register picks one of two output styles. In pulse style, each enabled event drives the line low for a fixed number of clock cycles. In level style, the line stays low as long as any enabled status bit is pending. There are two ways to release a level request. The processor can write the release bit in the control register, which clears both status registers. When auto-clear is on, the processor can instead read each status register that holds pending bits: each read clears the register that was read. The line then goes high only after every register with enabled pending bits has been read.

A synchronous reset returns all registers to zero and drives the line high.

Top module: `irq_out_ctrl`

## Requirements
- R1: While reset is high and after it falls, irq_n is 1 and every register address reads 0.
- R2: The register map is as follows. Address 2 is mask A and address 3 is mask B; both read back the full value written. Address 4 is the configuration register: bit 0 is level style (0 selects pulse style) and bit 1 is auto-clear. It reads back only those two bits, and all other bits read 0. Address 5 is control and always reads 0. Addresses 6 and 7 read 0. Writes to address 0 (status A) and address 1 (status B) have no effect.
- R3: Each event bit sets the matching status bit, and the bit stays set. A read with auto-clear off does not clear it.
- R4: In level style, irq_n is 0 in the cycle after an event sets an enabled bit. It is 0 exactly while some status bit has its mask bit set. Bits whose mask bit is clear never pull irq_n low.
- R5: Writing 1 to bit 0 of the control register clears both status registers. In level style, irq_n then goes high after that edge.
- R6: With auto-clear on, a read of a status register returns its value from before the read and clears that register at the same edge. irq_n goes high only after every status register with enabled pending bits has been read.
- R7: An event that arrives in the same cycle as a clear (a release write or an auto-clear read) still sets its status bit.
- R8: In pulse style, an event on an enabled bit drives irq_n low for exactly PULSE_CYC cycles, starting the cycle after the event. An event on a masked bit causes no pulse.
- R9: In pulse style, an enabled event during a running pulse restarts the full width.
- R10: In pulse style, status bits that remain pending do not hold irq_n low once the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from address |
| evt_a | input | DW | Event strobes for status register A |
| evt_b | input | DW | Event strobes for status register B |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A status bit that is lost or stuck shows up in two places. In level style it appears at irq_n one cycle after the event that should have changed it. In every style it appears on the next read of that register. A wrong clear decision, such as clearing the register that was not read or letting a clear override a simultaneous event, appears on the read immediately after the faulty edge. A faulty pulse counter changes the number of low cycles on irq_n, so the error becomes visible within PULSE_CYC cycles of the event.

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl #(
  parameter int DW        = 16,
  parameter int PULSE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] evt_a,
  input  logic [DW-1:0] evt_b,
  output logic          irq_n
);

  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [2:0] AD_STA = 3'd0;
  localparam logic [2:0] AD_STB = 3'd1;
  localparam logic [2:0] AD_MSA = 3'd2;
  localparam logic [2:0] AD_MSB = 3'd3;
  localparam logic [2:0] AD_CFG = 3'd4;
  localparam logic [2:0] AD_CTL = 3'd5;

  logic [DW-1:0] stat_a_q, stat_b_q, mask_a_q, mask_b_q;
  logic          lvl_q, auto_q;
  logic [CW-1:0] pcnt_q;

  wire rel   = reg_wr && reg_addr == AD_CTL && reg_wdata[0];
  wire clr_a = rel || (auto_q && reg_rd && reg_addr == AD_STA);
  wire clr_b = rel || (auto_q && reg_rd && reg_addr == AD_STB);
  wire fire  = |(evt_a & mask_a_q) || |(evt_b & mask_b_q);
  wire pend  = |(stat_a_q & mask_a_q) || |(stat_b_q & mask_b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_a_q <= '0;
      stat_b_q <= '0;
    end else begin
      stat_a_q <= (stat_a_q & ~{DW{clr_a}}) | evt_a;
      stat_b_q <= (stat_b_q & ~{DW{clr_b}}) | evt_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
      lvl_q    <= 1'b0;
      auto_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == AD_MSA) mask_a_q <= reg_wdata;
      if (reg_addr == AD_MSB) mask_b_q <= reg_wdata;
      if (reg_addr == AD_CFG) {auto_q, lvl_q} <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || lvl_q)
      pcnt_q <= '0;
    else if (fire)
      pcnt_q <= CW'(PULSE_CYC);
    else if (pcnt_q != '0)
      pcnt_q <= pcnt_q - 1'b1;
  end

  assign irq_n = lvl_q ? !pend : (pcnt_q == '0);

  always_comb begin
    case (reg_addr)
      AD_STA:  reg_rdata = stat_a_q;
      AD_STB:  reg_rdata = stat_b_q;
      AD_MSA:  reg_rdata = mask_a_q;
      AD_MSB:  reg_rdata = mask_b_q;
      AD_CFG:  reg_rdata = {{(DW-2){1'b0}}, auto_q, lvl_q};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_out_ctrl_chk.sv
module irq_out_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          rel_bit,
  input logic [DW-1:0] evt_a,
  input logic [DW-1:0] evt_b,
  input logic [DW-1:0] sta,
  input logic [DW-1:0] stb,
  input logic [DW-1:0] mska,
  input logic [DW-1:0] mskb,
  input logic          lvl,
  input logic          auto
);

  wire wr_rel = reg_wr && reg_addr == 3'd5 && rel_bit;
  wire rd_a   = reg_rd && reg_addr == 3'd0;

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> irq_n);

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_rel && !(auto && rd_a)) |=> ((sta & $past(sta)) == $past(sta)));

  // R4
  lvl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl && !reg_wr && (sta & mska) == '0 && (stb & mskb) == '0 &&
     (evt_a & mska) == '0 && (evt_b & mskb) == '0) |=> irq_n);

  // R5
  rel_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl && wr_rel && evt_a == '0 && evt_b == '0) |=> irq_n);

  // R6
  autoclr_chk: assert property (@(posedge clk) disable iff (rst)
    (auto && rd_a && evt_a == '0) |=> (sta == '0));

  // R7
  evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_b != '0) |=> ((stb & $past(evt_b)) == $past(evt_b)));

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl && !reg_wr && (evt_a & mska) != '0) |=> !irq_n);

endmodule

bind irq_out_ctrl irq_out_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .rel_bit(reg_wdata[0]), .evt_a(evt_a), .evt_b(evt_b),
  .sta(stat_a_q), .stb(stat_b_q), .mska(mask_a_q), .mskb(mask_b_q),
  .lvl(lvl_q), .auto(auto_q)
);

// File: tb/test_irq_out_ctrl.sv
module test_irq_out_ctrl;
  localparam int DW = 4;
  localparam int PW = 5;

  logic clk = 0, rst = 1, reg_wr = 0, reg_rd = 0, irq_n;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata, evt_a = '0, evt_b = '0;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_out_ctrl #(.DW(DW), .PULSE_CYC(PW)) i_irq_out_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_a(evt_a), .evt_b(evt_b),
    .irq_n(irq_n));

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = DW'(d);
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_rd = 1; reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
    tick();
    reg_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d, lows;
    tick(); tick();
    chk("R1 irq in reset", int'(irq_n), 1);
    rst = 0;
    tick();
    chk("R1 irq after reset", int'(irq_n), 1);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk("R1 reg after reset", d, 0);
    end

    for (int v = 0; v < 16; v++) begin
      wr(2, v); rd(2, d); chk("R2 mask A readback", d, v);
      wr(3, 15 - v); rd(3, d); chk("R2 mask B readback", d, 15 - v);
      wr(4, v); rd(4, d); chk("R2 config readback", d, v & 3);
      wr(5, v & 14); rd(5, d); chk("R2 control reads zero", d, 0);
      wr(0, v); rd(0, d); chk("R2 status A write ignored", d, 0);
      wr(1, v); rd(1, d); chk("R2 status B write ignored", d, 0);
    end
    rd(6, d); chk("R2 addr 6", d, 0);
    rd(7, d); chk("R2 addr 7", d, 0);

    wr(4, 1);
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 16; m++)
        for (int e = 0; e < 16; e++) begin
          wr(2, s == 0 ? m : 0);
          wr(3, s == 0 ? 0 : m);
          wr(5, 1);
          chk("R5 released", int'(irq_n), 1);
          if (s == 0) evt_a = 4'(e); else evt_b = 4'(e);
          tick();
          evt_a = '0; evt_b = '0;
          chk("R4 level follows enabled bits", int'(irq_n), (e & m) != 0 ? 0 : 1);
          rd(s, d); chk("R3 status set", d, e);
          rd(s, d); chk("R3 status sticky", d, e);
          chk("R4 level held", int'(irq_n), (e & m) != 0 ? 0 : 1);
        end
    wr(5, 1);
    rd(0, d); chk("R5 status A cleared", d, 0);
    rd(1, d); chk("R5 status B cleared", d, 0);

    wr(2, 15); wr(3, 15); wr(4, 3);
    for (int o = 0; o < 2; o++) begin
      wr(5, 1);
      evt_a = 4'h3; evt_b = 4'h8;
      tick();
      evt_a = '0; evt_b = '0;
      chk("R6 pending low", int'(irq_n), 0);
      rd(o, d); chk("R6 first read pre-clear", d, o == 0 ? 3 : 8);
      chk("R6 other still pending", int'(irq_n), 0);
      rd(1 - o, d); chk("R6 second read pre-clear", d, o == 0 ? 8 : 3);
      chk("R6 released after both", int'(irq_n), 1);
      rd(0, d); chk("R6 A cleared", d, 0);
      rd(1, d); chk("R6 B cleared", d, 0);
    end

    evt_a = 4'h1; tick(); evt_a = '0;
    reg_rd = 1; reg_addr = 3'd0; evt_a = 4'h4;
    #1 chk("R7 read returns old", int'(reg_rdata), 1);
    tick();
    reg_rd = 0; evt_a = '0;
    chk("R7 event kept on read clear", int'(irq_n), 0);
    rd(0, d); chk("R7 new bit present", d, 4);
    evt_b = 4'h2; wr(5, 1); evt_b = '0;
    chk("R7 event kept on release", int'(irq_n), 0);
    rd(1, d); chk("R7 B bit present", d, 2);
    chk("R6 single read releases", int'(irq_n), 1);

    wr(4, 0); wr(2, 5); wr(3, 5);
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 16; e++) begin
        wr(5, 1);
        repeat (PW + 1) tick();
        if (s == 0) evt_a = 4'(e); else evt_b = 4'(e);
        tick();
        evt_a = '0; evt_b = '0;
        chk("R8 pulse start", int'(irq_n), (e & 5) != 0 ? 0 : 1);
        lows = irq_n ? 0 : 1;
        repeat (PW + 2) begin
          tick();
          if (!irq_n) lows++;
        end
        chk("R8 pulse width", lows, (e & 5) != 0 ? PW : 0);
      end
    chk("R10 line high with pending", int'(irq_n), 1);
    rd(1, d); chk("R10 status still pending", d, 15);

    lows = 0;
    for (int i = 0; i < PW + 6; i++) begin
      evt_a = (i == 0 || i == 2) ? 4'h1 : 4'h0;
      tick();
      evt_a = '0;
      if (!irq_n) lows++;
    end
    chk("R9 retrigger width", lows, PW + 2);

    finish_run();
  end
endmodule